// File: doc/BRIEF.md
# GPIO Port with Peripheral Override

This block is a narrow general-purpose I/O port. Every pin can be an input or an output. Software controls each pin through a set of registers: a direction register, an output latch, an analog-select mask and an open-drain mask. Reading the port register returns the synchronized pin levels.

On-chip peripherals can take a pin over without software involvement. They can force it to drive a value, force it to act as an input, or, during a PWM shutdown event, force it to high impedance. These overrides act only on the pad. The direction register keeps the value software last wrote, so software can safely read, modify and write it back while a peripheral holds a pin.

Pins selected as analog return 0 on the digital input path, while their output driver keeps working. Analog mode is selected on every pin after reset.

Top module: `gpio_ovr_port`

## Requirements
- R1: After reset, the register values are:
  - direction register: all 1 (all inputs);
  - latch: all 0;
  - analog-select: all 1;
  - open-drain: all 0.
  Every pad_oe bit is 0 after reset.
- R2: With no override active and open-drain off, a direction bit of 0 sets pad_oe for that pin and drives the latch bit on pad_o. A direction bit of 1 clears pad_oe.
- R3: A write to either the latch address or the port address loads wdata into the latch on the next rising edge. A read of the latch address returns the latch contents.
- R4: A read of the port address returns pad_i through a two-flop synchronizer. A level applied before a rising edge appears in rdata after the second rising edge, not after the first.
- R5: A pin whose analog-select bit is 1 reads as 0 on both the port read and pin_din. Its output driver still follows the direction and latch bits.
- R6: When pf_out_en is 1 on a pin, pad_oe is 1 and pad_o equals pf_out_val, regardless of the direction and latch bits. This holds unless open-drain or shutdown applies.
- R7: When pf_in_en is 1 on a pin, pad_oe is 0 regardless of the direction bit. When pf_out_en and pf_in_en are both 1, the force-output behaviour of R6 applies.
- R8: Overrides never change the direction register. A read of the direction address always returns the value software last wrote.
- R9: With the open-drain bit set, a pin whose drive value is 1 is released (pad_oe 0). A pin whose drive value is 0 drives low (pad_oe 1, pad_o 0). This applies both to latch data and to peripheral data.
- R10: While pwm_shut is 1 on a pin, that pin's pad_oe is 0, whatever the other inputs are.
- R11: The register addresses are:
  - 0: direction;
  - 1: latch;
  - 2: port;
  - 3: analog-select;
  - 4: open-drain.
  Writes to addresses 5 to 7 change nothing, and reads of those addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 5 | Register write data |
| rdata | output | 5 | Register read data (combinational from addr) |
| pad_i | input | 5 | Pad input levels |
| pad_o | output | 5 | Pad output data |
| pad_oe | output | 5 | Pad output enable (1 = drive) |
| pin_din | output | 5 | Synchronized digital input for peripherals, 0 on analog pins |
| pf_out_en | input | 5 | Peripheral force-output per pin |
| pf_out_val | input | 5 | Peripheral output value per pin |
| pf_in_en | input | 5 | Peripheral force-input per pin |
| pwm_shut | input | 5 | PWM shutdown tri-state request per pin |

## Verification
The bench targets the following corner cases:
- Force-output and force-input asserted on the same pin. A design with the priority reversed releases a pin that should be driving.
- Reading the direction register while overrides are active. A design that writes the forced direction back into the register returns altered bits.
- The synchronizer latency. Samples are taken after exactly one edge and after two edges, which catches a missing or an extra stage.
- Open-drain with a high value from both the latch and a peripheral. A design that ignores open-drain there drives the pad high instead of releasing it.
- A shutdown stacked on a forced output. A design that gives shutdown lower priority keeps driving the pad.

// File: rtl/gpio_ovr_pkg.sv
package gpio_ovr_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_DIR  = 3'd0,
    A_LAT  = 3'd1,
    A_PORT = 3'd2,
    A_ASEL = 3'd3,
    A_ODEN = 3'd4
  } reg_addr_e;

  typedef struct packed {
    logic oe;
    logic o;
  } pad_drv_t;

  // Per-pin drive resolution: shutdown > force-out > force-in > direction,
  // with open-drain releasing any high drive value.
  function automatic pad_drv_t pin_drive(input logic dir_b, input logic lat_b,
                                         input logic od_b, input logic fo,
                                         input logic fv, input logic fi,
                                         input logic sd);
    pad_drv_t r;
    if (fo) begin
      r.oe = 1'b1;
      r.o  = fv;
    end else if (fi) begin
      r.oe = 1'b0;
      r.o  = lat_b;
    end else begin
      r.oe = ~dir_b;
      r.o  = lat_b;
    end
    if (od_b && r.o) r.oe = 1'b0;
    if (sd) r.oe = 1'b0;
    return r;
  endfunction
endpackage

// File: rtl/gpio_ovr_regs.sv
module gpio_ovr_regs
  import gpio_ovr_pkg::*;
#(
  parameter int NPIN = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NPIN-1:0]   wdata,
  output logic [NPIN-1:0]   dir_q,
  output logic [NPIN-1:0]   lat_q,
  output logic [NPIN-1:0]   asel_q,
  output logic [NPIN-1:0]   od_q,
  output logic              wr_dir,
  output logic              wr_lat
);
  logic wr_asel, wr_od;

  always_comb begin
    wr_dir  = 1'b0;
    wr_lat  = 1'b0;
    wr_asel = 1'b0;
    wr_od   = 1'b0;
    if (wr_en) begin
      case (reg_addr_e'(addr))
        A_DIR:          wr_dir  = 1'b1;
        A_LAT, A_PORT:  wr_lat  = 1'b1;
        A_ASEL:         wr_asel = 1'b1;
        A_ODEN:         wr_od   = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '1;
      lat_q  <= '0;
      asel_q <= '1;
      od_q   <= '0;
    end else begin
      if (wr_dir)  dir_q  <= wdata;
      if (wr_lat)  lat_q  <= wdata;
      if (wr_asel) asel_q <= wdata;
      if (wr_od)   od_q   <= wdata;
    end
  end
endmodule

// File: rtl/gpio_ovr_sync.sv
module gpio_ovr_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= '0;
      else if (s == 0) stg[s] <= d;
      else stg[s] <= stg[(s == 0) ? 0 : s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_ovr_pinmux.sv
module gpio_ovr_pinmux
  import gpio_ovr_pkg::*;
#(
  parameter int NPIN = 5
) (
  input  logic [NPIN-1:0] dir_q,
  input  logic [NPIN-1:0] lat_q,
  input  logic [NPIN-1:0] od_q,
  input  logic [NPIN-1:0] pf_out_en,
  input  logic [NPIN-1:0] pf_out_val,
  input  logic [NPIN-1:0] pf_in_en,
  input  logic [NPIN-1:0] pwm_shut,
  output logic [NPIN-1:0] pad_o,
  output logic [NPIN-1:0] pad_oe
);
  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    pad_drv_t drv;
    assign drv = pin_drive(dir_q[i], lat_q[i], od_q[i], pf_out_en[i],
                           pf_out_val[i], pf_in_en[i], pwm_shut[i]);
    assign pad_o[i]  = drv.o;
    assign pad_oe[i] = drv.oe;
  end
endmodule

// File: rtl/gpio_ovr_port.sv
module gpio_ovr_port
  import gpio_ovr_pkg::*;
#(
  parameter int NPIN        = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NPIN-1:0]   wdata,
  output logic [NPIN-1:0]   rdata,
  input  logic [NPIN-1:0]   pad_i,
  output logic [NPIN-1:0]   pad_o,
  output logic [NPIN-1:0]   pad_oe,
  output logic [NPIN-1:0]   pin_din,
  input  logic [NPIN-1:0]   pf_out_en,
  input  logic [NPIN-1:0]   pf_out_val,
  input  logic [NPIN-1:0]   pf_in_en,
  input  logic [NPIN-1:0]   pwm_shut
);
  logic [NPIN-1:0] dir_q, lat_q, asel_q, od_q;
  logic [NPIN-1:0] sync_q;
  logic            wr_dir, wr_lat;

  gpio_ovr_regs #(.NPIN(NPIN)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .dir_q(dir_q), .lat_q(lat_q), .asel_q(asel_q), .od_q(od_q),
    .wr_dir(wr_dir), .wr_lat(wr_lat)
  );

  gpio_ovr_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_i), .q(sync_q)
  );

  gpio_ovr_pinmux #(.NPIN(NPIN)) u_mux (
    .dir_q(dir_q), .lat_q(lat_q), .od_q(od_q),
    .pf_out_en(pf_out_en), .pf_out_val(pf_out_val), .pf_in_en(pf_in_en),
    .pwm_shut(pwm_shut), .pad_o(pad_o), .pad_oe(pad_oe)
  );

  // Analog-selected pins read as 0 on the digital path.
  assign pin_din = sync_q & ~asel_q;

  always_comb begin
    case (reg_addr_e'(addr))
      A_DIR:   rdata = dir_q;
      A_LAT:   rdata = lat_q;
      A_PORT:  rdata = pin_din;
      A_ASEL:  rdata = asel_q;
      A_ODEN:  rdata = od_q;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_ovr_chk.sv
module gpio_ovr_chk #(
  parameter int NPIN = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic [2:0]      addr,
  input logic [NPIN-1:0] wdata,
  input logic [NPIN-1:0] pad_i,
  input logic [NPIN-1:0] pad_o,
  input logic [NPIN-1:0] pad_oe,
  input logic [NPIN-1:0] pin_din,
  input logic [NPIN-1:0] pf_out_en,
  input logic [NPIN-1:0] pf_out_val,
  input logic [NPIN-1:0] pf_in_en,
  input logic [NPIN-1:0] pwm_shut,
  input logic [NPIN-1:0] dir_q,
  input logic [NPIN-1:0] lat_q,
  input logic [NPIN-1:0] asel_q,
  input logic [NPIN-1:0] sync_q,
  input logic            wr_dir,
  input logic            wr_lat
);
  logic [1:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  // R10: shutdown releases the pad
  p_shut_hiz_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & pwm_shut) == '0);

  // R6: forced output value reaches the pad
  p_force_val_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((pf_out_en & ~pwm_shut) & (pad_o ^ pf_out_val)) == '0);

  // R7: force-input alone releases the pad
  p_force_in_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_in_en & ~pf_out_en & pad_oe) == '0);

  // R8: direction register moves only on a software write
  p_dir_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_dir |=> $stable(dir_q));

  // R3: latch loads the written data
  p_lat_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lat |=> lat_q == $past(wdata));

  // R4: two-edge synchronizer latency
  p_sync_lat_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2'd2) |-> sync_q == $past(pad_i, 2));

  // R5: analog pins read 0
  p_ana_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_din & asel_q) == '0);

  // R11: unused addresses never write
  p_bad_addr_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (addr > 3'd4) |-> !wr_dir && !wr_lat);
endmodule

bind gpio_ovr_port gpio_ovr_chk #(.NPIN(NPIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .pad_i(pad_i),
  .pad_o(pad_o), .pad_oe(pad_oe), .pin_din(pin_din),
  .pf_out_en(pf_out_en), .pf_out_val(pf_out_val), .pf_in_en(pf_in_en),
  .pwm_shut(pwm_shut), .dir_q(dir_q), .lat_q(lat_q), .asel_q(asel_q),
  .sync_q(sync_q), .wr_dir(wr_dir), .wr_lat(wr_lat)
);

// File: tb/gpio_ovr_port_tb.sv
module gpio_ovr_port_tb;
  localparam int N = 5;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [2:0]   addr = 3'd0;
  logic [N-1:0] wdata = '0;
  logic [N-1:0] rdata, pad_o, pad_oe, pin_din;
  logic [N-1:0] pad_i = '0;
  logic [N-1:0] fo = '0, fv = '0, fi = '0, sd = '0;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // software shadow of the registers
  logic [N-1:0] s_dir = '1, s_lat = '0, s_od = '0;

  always #10 clk = ~clk;

  gpio_ovr_port u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pad_i(pad_i), .pad_o(pad_o), .pad_oe(pad_oe),
    .pin_din(pin_din), .pf_out_en(fo), .pf_out_val(fv), .pf_in_en(fi),
    .pwm_shut(sd)
  );

  task automatic chk(input string req, input logic [N-1:0] act,
                     input logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    case (a)
      3'd0: s_dir = d;
      3'd1, 3'd2: s_lat = d;
      3'd4: s_od = d;
      default: ;
    endcase
  endtask

  task automatic rd(input logic [2:0] a, output logic [N-1:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  // expected pad state, written as bit-vector equations
  task automatic chk_pads(input string req);
    logic [N-1:0] hi, oe_e, o_e;
    hi   = (fo & fv) | (~fo & s_lat);
    oe_e = ~sd & ~(s_od & hi) & (fo | (~fi & ~s_dir));
    o_e  = hi;
    #1;
    chk({req, " oe"}, pad_oe, oe_e);
    chk({req, " o"}, pad_o & oe_e, o_e & oe_e);
  endtask

  task automatic t_reset;
    logic [N-1:0] v;
    rd(3'd0, v); chk("R1 dir", v, '1);
    rd(3'd1, v); chk("R1 lat", v, '0);
    rd(3'd3, v); chk("R1 asel", v, '1);
    rd(3'd4, v); chk("R1 od", v, '0);
    chk("R1 pad_oe", pad_oe, '0);
  endtask

  task automatic t_dir_out;
    wr(3'd1, 5'b01011);
    wr(3'd0, 5'b10100);
    chk_pads("R2 pat1");
    wr(3'd0, 5'b01001);
    wr(3'd1, 5'b10110);
    chk_pads("R2 pat2");
  endtask

  task automatic t_latch;
    logic [N-1:0] v;
    wr(3'd2, 5'b10110);
    rd(3'd1, v); chk("R3 port-addr write", v, 5'b10110);
    wr(3'd1, 5'b01001);
    rd(3'd1, v); chk("R3 latch write", v, 5'b01001);
  endtask

  task automatic t_sync;
    logic [N-1:0] v;
    wr(3'd3, 5'b00000);
    @(negedge clk); pad_i = 5'b00000;
    repeat (3) @(negedge clk);
    pad_i = 5'b10101;
    @(negedge clk);
    rd(3'd2, v); chk("R4 one edge", v, 5'b00000);
    @(negedge clk);
    rd(3'd2, v); chk("R4 two edges", v, 5'b10101);
  endtask

  task automatic t_analog;
    logic [N-1:0] v;
    wr(3'd3, 5'b00011);
    pad_i = 5'b11111;
    repeat (3) @(negedge clk);
    rd(3'd2, v); chk("R5 port read", v, 5'b11100);
    chk("R5 pin_din", pin_din, 5'b11100);
    wr(3'd0, 5'b11110);
    wr(3'd1, 5'b00001);
    chk_pads("R5 analog pin drives");
  endtask

  task automatic t_force_out;
    logic [N-1:0] v;
    wr(3'd0, 5'b11111);
    wr(3'd1, 5'b00010);
    fo = 5'b00110; fv = 5'b00100;
    chk_pads("R6 force out");
    wr(3'd0, 5'b11011);
    rd(3'd0, v); chk("R8 dir readback", v, 5'b11011);
    repeat (2) @(negedge clk);
    rd(3'd0, v); chk("R8 dir held", v, 5'b11011);
    fo = '0; fv = '0;
  endtask

  task automatic t_force_in;
    logic [N-1:0] v;
    wr(3'd0, 5'b00000);
    fi = 5'b01100; fo = 5'b01000; fv = 5'b01000;
    chk_pads("R7 force in / both");
    rd(3'd0, v); chk("R8 dir under force", v, 5'b00000);
    fi = '0; fo = '0; fv = '0;
  endtask

  task automatic t_open_drain;
    wr(3'd4, 5'b00111);
    wr(3'd0, 5'b00000);
    wr(3'd1, 5'b00001);
    chk_pads("R9 latch od");
    fo = 5'b00100; fv = 5'b00100;
    chk_pads("R9 periph od");
    fo = '0; fv = '0;
    wr(3'd4, 5'b00000);
  endtask

  task automatic t_shutdown;
    fo = 5'b00011; fv = 5'b00010; sd = 5'b00010;
    chk_pads("R10 shutdown");
    sd = 5'b11111;
    chk_pads("R10 all shut");
    fo = '0; fv = '0; sd = '0;
  endtask

  task automatic t_bad_addr;
    logic [N-1:0] v;
    wr(3'd0, 5'b10101);
    wr(3'd1, 5'b01010);
    wr(3'd5, 5'b11111);
    wr(3'd6, 5'b00000);
    wr(3'd7, 5'b11111);
    rd(3'd0, v); chk("R11 dir kept", v, 5'b10101);
    rd(3'd1, v); chk("R11 lat kept", v, 5'b01010);
    rd(3'd4, v); chk("R11 od kept", v, 5'b00000);
    rd(3'd6, v); chk("R11 read 0", v, 5'b00000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_dir_out();
    t_latch();
    t_sync();
    t_analog();
    t_force_out();
    t_force_in();
    t_open_drain();
    t_shutdown();
    t_bad_addr();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule